// File: doc/BRIEF.md
# Occupancy-Steered Rate Recovery Loop

This block recovers a steady output sample rate from input data that arrives in bursts or at a slightly wrong rate. Writes push samples into a small elastic buffer. A phase accumulator, clocked every system cycle, produces the read strobe that drains the buffer. Its step comes from a proportional-integral loop that is steered by how far the buffer occupancy sits from half full.

The occupancy error is bounded by the buffer's empty and full limits, so it can never wrap. The loop filter runs once per programmable update period. Its gains are arithmetic right shifts, and there is one shift pair for the acquiring state and another for the locked state. A hysteresis detector moves the loop between the two states. Buffer misuse is recorded in two sticky flags. The whole block runs on one system clock.

Top module: `rate_lock_loop`

## Requirements
- R1: During and just after reset, `fill`, `rd_valid`, `locked`, `ovf_flag`, `unf_flag` and `rd_data` are 0, and `step_out` equals `f_min`.
- R2: A write into a buffer that is not full stores `wr_data`. Samples leave in write order, and `fill` counts the stored samples from 0 to 2^AW.
- R3: A write while `fill` equals 2^AW is dropped and sets the sticky `ovf_flag`. A read strobe in that same cycle still removes a sample.
- R4: The phase accumulator is FW bits wide and starts at 0. Each cycle it adds `step_out`, and a read strobe occurs in each cycle where that sum carries out. `rd_valid` is high in the next cycle, with the removed sample on `rd_data`.
- R5: A read strobe on an empty buffer still raises `rd_valid`, repeats the previous `rd_data`, and sets the sticky `unf_flag`. A write in that same cycle is stored.
- R6: Loop updates happen at clock edges `upd_div`, 2·`upd_div`, … counted after reset release. Each update uses the error e = `fill` − 2^(AW−1), taken from `fill` just before that edge. Between updates `step_out` holds.
- R7: At each update the integrator becomes clamp(I + (e >>> ki)), with I starting at `f_min`. The new `step_out` is clamp(I_new + (e >>> kp)), where >>> is an arithmetic shift.
- R8: Both clamps limit the value to the range [`f_min`, `f_max`].
- R9: While acquiring, `locked` rises at the update that completes `lock_len` consecutive updates with |e| ≤ `lock_win`. An update outside that window restarts the count.
- R10: While locked, an update with |e| > `unlock_win` clears `locked`. Updates with |e| ≤ `unlock_win` keep it set.
- R11: Each update uses the gains `kp_lock`/`ki_lock` if `locked` was set before that update, and `kp_acq`/`ki_acq` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| wr_en | input | 1 | write strobe |
| wr_data | input | DW | sample to write |
| rd_data | output | DW | last sample read |
| rd_valid | output | 1 | read strobe, one cycle per read |
| fill | output | AW+1 | buffer occupancy |
| locked | output | 1 | 1 = locked, 0 = acquiring |
| ovf_flag | output | 1 | sticky: a write was dropped |
| unf_flag | output | 1 | sticky: a read hit an empty buffer |
| step_out | output | FW | current phase step |
| upd_div | input | CW | loop update period in cycles |
| kp_acq | input | SHW | proportional shift while acquiring |
| ki_acq | input | SHW | integral shift while acquiring |
| kp_lock | input | SHW | proportional shift while locked |
| ki_lock | input | SHW | integral shift while locked |
| lock_win | input | AW+1 | error window for entering lock |
| unlock_win | input | AW+1 | error window for leaving lock |
| lock_len | input | LCW | in-window updates needed to lock |
| f_min | input | FW | lower clamp and reset step |
| f_max | input | FW | upper clamp |

## Verification
A read strobe can fall in the same cycle as a write into a full buffer, and also in the same cycle as a write into an empty buffer. The bench fixes the step at half scale, so reads occur on every second edge, and it writes on every edge. The buffer then fills, and the write on edge 32 meets a read on a full buffer. There the bench expects the dropped write, a fill of 15 and the sixteenth sample on the output. After the buffer drains, a single write on edge 64 meets a read on an empty buffer. The bench expects the repeated previous sample and a fill of 1, and the next read must then return the sample written on edge 64.

// File: rtl/rate_lock_loop.sv
`timescale 1ns/1ps
module rate_lock_loop #(
  parameter int DW  = 8,
  parameter int AW  = 4,
  parameter int FW  = 16,
  parameter int CW  = 16,
  parameter int LCW = 8,
  parameter int SHW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [DW-1:0]  wr_data,
  output logic [DW-1:0]  rd_data,
  output logic           rd_valid,
  output logic [AW:0]    fill,
  output logic           locked,
  output logic           ovf_flag,
  output logic           unf_flag,
  output logic [FW-1:0]  step_out,
  input  logic [CW-1:0]  upd_div,
  input  logic [SHW-1:0] kp_acq,
  input  logic [SHW-1:0] ki_acq,
  input  logic [SHW-1:0] kp_lock,
  input  logic [SHW-1:0] ki_lock,
  input  logic [AW:0]    lock_win,
  input  logic [AW:0]    unlock_win,
  input  logic [LCW-1:0] lock_len,
  input  logic [FW-1:0]  f_min,
  input  logic [FW-1:0]  f_max
);
  localparam int DEPTH = 1 << AW;
  localparam int EW = AW + 2;
  localparam int IW = FW + 2;
  localparam logic [AW:0]   FULLV = (AW+1)'(DEPTH);
  localparam logic [EW-1:0] MID   = EW'(DEPTH / 2);

  function automatic logic [FW-1:0] sat(input logic signed [IW-1:0] v,
                                        input logic signed [IW-1:0] lo_v,
                                        input logic signed [IW-1:0] hi_v);
    if (v > hi_v) return hi_v[FW-1:0];
    if (v < lo_v) return lo_v[FW-1:0];
    return v[FW-1:0];
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [FW-1:0] ph, integ;
  logic [FW:0]   ph_sum;
  logic          strobe, full, empty, push, pop, tick;
  logic [CW-1:0] div_q;
  logic [LCW-1:0] run;

  assign ph_sum = {1'b0, ph} + {1'b0, step_out};
  assign strobe = ph_sum[FW];
  assign full   = fill == FULLV;
  assign empty  = fill == '0;
  assign push   = wr_en && !full;
  assign pop    = strobe && !empty;

  always_ff @(posedge clk)
    if (push) mem[wp] <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; fill <= '0; ph <= '0;
      rd_valid <= 1'b0; rd_data <= '0; ovf_flag <= 1'b0; unf_flag <= 1'b0;
    end else begin
      ph       <= ph_sum[FW-1:0];
      rd_valid <= strobe;
      if (push) wp <= wp + 1'b1;
      if (pop) begin
        rp      <= rp + 1'b1;
        rd_data <= mem[rp];
      end
      fill     <= fill + {{AW{1'b0}}, push} - {{AW{1'b0}}, pop};
      ovf_flag <= ovf_flag | (wr_en & full);
      unf_flag <= unf_flag | (strobe & empty);
    end

  logic signed [EW-1:0] err;
  logic [EW-1:0]        mag;
  logic                 in_win, out_wide;
  logic signed [IW-1:0] ex, p_term, i_term, lo, hi, i_sum, f_sum;
  logic [FW-1:0]        i_nxt, f_nxt;

  assign err      = $signed({1'b0, fill}) - $signed(MID);
  assign mag      = err[EW-1] ? -err : err;
  assign in_win   = mag <= {1'b0, lock_win};
  assign out_wide = mag > {1'b0, unlock_win};
  assign ex       = {{(IW-EW){err[EW-1]}}, err};
  assign p_term   = ex >>> (locked ? kp_lock : kp_acq);
  assign i_term   = ex >>> (locked ? ki_lock : ki_acq);
  assign lo       = {2'b00, f_min};
  assign hi       = {2'b00, f_max};
  assign i_sum    = $signed({2'b00, integ}) + i_term;
  assign i_nxt    = sat(i_sum, lo, hi);
  assign f_sum    = $signed({2'b00, i_nxt}) + p_term;
  assign f_nxt    = sat(f_sum, lo, hi);
  assign tick     = ({1'b0, div_q} + (CW+1)'(1)) >= {1'b0, upd_div};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_q <= '0; integ <= f_min; step_out <= f_min; locked <= 1'b0; run <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) begin
        integ    <= i_nxt;
        step_out <= f_nxt;
        if (locked) begin
          if (out_wide) begin
            locked <= 1'b0;
            run    <= '0;
          end
        end else if (in_win) begin
          if (({1'b0, run} + (LCW+1)'(1)) >= {1'b0, lock_len}) begin
            locked <= 1'b1;
            run    <= '0;
          end else begin
            run <= run + 1'b1;
          end
        end else begin
          run <= '0;
        end
      end
    end
endmodule

// File: rtl/rate_lock_loop_chk.sv
`timescale 1ns/1ps
module rate_lock_loop_chk #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW:0]   fill,
  input logic [DW-1:0] rd_data,
  input logic          ovf_flag,
  input logic          unf_flag
);
  localparam logic [AW:0] FULLV = (AW+1)'(1 << AW);
  localparam logic [AW:0] ONE   = (AW+1)'(1);

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) fill <= FULLV); // R2
  AST_FILL_STEP:  assert property (@(posedge clk) disable iff (!rst_n)
    (fill == $past(fill)) || (fill == $past(fill) + ONE) || (fill + ONE == $past(fill))); // R2
  AST_OVF_SET:    assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fill == FULLV) |=> ovf_flag); // R3
  AST_OVF_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) ovf_flag |=> ovf_flag); // R3
  AST_UNF_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) unf_flag |=> unf_flag); // R5
  AST_EMPTY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == '0) |=> $stable(rd_data)); // R5
endmodule

bind rate_lock_loop rate_lock_loop_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .fill(fill),
  .rd_data(rd_data), .ovf_flag(ovf_flag), .unf_flag(unf_flag));

// File: tb/rate_lock_loop_test.sv
`timescale 1ns/1ps
module rate_lock_loop_test;
  localparam int DW = 8, AW = 4, FW = 16, CW = 16, LCW = 8, SHW = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic rd_valid, locked, ovf_flag, unf_flag;
  logic [AW:0] fill, lock_win = '0, unlock_win = '0;
  logic [FW-1:0] step_out, f_min = '0, f_max = '0;
  logic [CW-1:0] upd_div = '1;
  logic [SHW-1:0] kp_acq = '0, ki_acq = '0, kp_lock = '0, ki_lock = '0;
  logic [LCW-1:0] lock_len = '1;

  rate_lock_loop uut (.*);

  int errors = 0, checks = 0;

  // fill n, kp, ki, f_min, f_max, step after 1st update, step after 2nd update
  localparam int VEC [5][7] = '{
    '{12, 0, 0,  0, 1000,  8, 12},
    '{16, 1, 2,  0, 1000,  6,  8},
    '{ 4, 0, 0, 40, 1000, 40, 40},
    '{16, 0, 0,  0,   20, 16, 20},
    '{ 9, 2, 5,  0, 1000,  0,  0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wr_en = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] q [64];
    logic [7:0] last;
    int hd, tl, mc;
    bit movf, munf;

    // reset state
    f_min = 16'd40; f_max = 16'd1000;
    rst_n = 1'b0;
    repeat (2) cyc();
    chk("R1 fill", fill, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 locked", locked, 0);
    chk("R1 flags", {ovf_flag, unf_flag}, 0);
    chk("R1 step", step_out, 40);
    chk("R1 rd_data", rd_data, 0);

    // loop filter vectors
    for (int v = 0; v < 5; v++) begin
      kp_acq = SHW'(VEC[v][1]); ki_acq = SHW'(VEC[v][2]);
      f_min = FW'(VEC[v][3]); f_max = FW'(VEC[v][4]);
      upd_div = 16'd64; lock_len = 8'd255; lock_win = '0; unlock_win = 5'd16;
      do_reset();
      for (int k = 1; k <= 128; k++) begin
        wr_en = (k <= VEC[v][0]);
        wr_data = 8'(k);
        cyc();
        if (k == 63) chk("R6 step before update", step_out, VEC[v][3]);
        if (k == 64) chk("R7 R8 step after update 1", step_out, VEC[v][5]);
        if (k == 128) chk("R7 R8 step after update 2", step_out, VEC[v][6]);
      end
      chk("R2 fill count", fill, VEC[v][0]);
    end

    // buffer session: reads on every even edge
    f_min = 16'd32768; f_max = 16'hFFFF; upd_div = 16'hFFFF;
    do_reset();
    hd = 0; tl = 0; mc = 0; last = '0; movf = 0; munf = 0;
    for (int k = 1; k <= 66; k++) begin
      bit rd, wr;
      wr = (k <= 32) || (k == 64);
      rd = (k % 2 == 0);
      wr_en = wr;
      wr_data = (k <= 32) ? 8'(8'h40 + k) : 8'hC3;
      cyc();
      if (rd && mc == 0) munf = 1;
      if (wr && mc == 16) movf = 1;
      begin
        bit pp, ps;
        pp = rd && (mc != 0);
        ps = wr && (mc != 16);
        if (pp) begin last = q[hd]; hd++; end
        if (ps) begin q[tl] = 8'(wr_data); tl++; end
        mc = mc + int'(ps) - int'(pp);
      end
      chk("R2 fill track", fill, mc);
      chk("R4 rd_valid cadence", rd_valid, int'(rd));
      if (rd) chk("R4 read order", rd_data, last);
      if (k == 32) begin
        chk("R3 full write with read: fill", fill, 15);
        chk("R3 full write with read: ovf", ovf_flag, 1);
        chk("R3 full write with read: data", rd_data, 8'h50);
      end
      if (k == 64) begin
        chk("R5 empty read with write: fill", fill, 1);
        chk("R5 empty read with write: unf", unf_flag, 1);
        chk("R5 empty read repeats", rd_data, 8'h5F);
        chk("R5 empty read valid", rd_valid, 1);
      end
      if (k == 66) chk("R5 write kept on empty read", rd_data, 8'hC3);
    end
    chk("R3 ovf sticky", ovf_flag, int'(movf));
    chk("R5 unf sticky", unf_flag, int'(munf));

    // lock hysteresis and gain selection
    f_min = 16'd0; f_max = 16'd1000; upd_div = 16'd4;
    kp_acq = 4'd4; ki_acq = 4'd4; kp_lock = 4'd0; ki_lock = 4'd0;
    lock_win = 5'd1; unlock_win = 5'd3; lock_len = 8'd3;
    do_reset();
    for (int k = 1; k <= 24; k++) begin
      wr_en = (k <= 8) || k == 17 || k == 18 || k == 21 || k == 22;
      wr_data = 8'(k);
      cyc();
      if (k == 12) chk("R9 not yet locked", locked, 0);
      if (k == 16) chk("R9 locked after run", locked, 1);
      if (k == 16) chk("R11 acquiring gains", step_out, 0);
      if (k == 19) chk("R6 step holds between updates", step_out, 0);
      if (k == 20) chk("R10 stays locked inside wide window", locked, 1);
      if (k == 20) chk("R11 locked gains", step_out, 4);
      if (k == 24) chk("R10 unlock outside wide window", locked, 0);
      if (k == 24) chk("R11 gains of prior state", step_out, 10);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule